// File: doc/BRIEF.md
# PCI Configuration Register Responder for a Display Function

This block holds the type-0 configuration header of a single-function VGA-class display device. The host side reaches it through a byte-wide access port: a one-cycle request strobe with a write flag, an 8-bit offset and 8-bit write data. A read returns its byte one cycle later, flagged by a valid strobe. Writes take effect at the request edge.

The block also drives the decode controls that the rest of the display function uses. These are the I/O and memory enables, the top byte of the frame-buffer base, the expansion-ROM enable and base, and the interrupt line. A small I/O-port comparator is gated by the I/O enable and flags accesses to the 32-port legacy VGA window starting at 0x3C0. A write that can move an aperture produces a one-cycle remap pulse for the address decoder.

The access port is driven by a two-state machine. `ST_IDLE` is the idle state. `ST_RESP` is the state in which the read byte is presented. The machine has three transitions:
- *rd_accept*: from either state to `ST_RESP` when a read request arrives.
- *resp_done*: from `ST_RESP` to `ST_IDLE` when no read request arrives.
- *idle_hold*: from `ST_IDLE` to itself when no read request arrives.

Writes never leave `ST_IDLE` on their own account.

Top module: `pcfg_responder`

## Requirements
- R1: Offsets 0x00, 0x01, 0x02, 0x03 read 0x13, 0x10, the device-ID low byte, 0x00. The device-ID low byte is 0xA0 when parameter DEV_SUPPORTED is 1 and 0xFF when it is 0. Writes to these offsets change nothing.
- R2: The command byte at offset 0x04 resets to 0x07. A write stores `wdata & 0x23`. Output io_en is command bit 0 and mem_en is command bit 1.
- R3: vga_io_hit is 1 exactly when io_en is 1 and io_port lies in 0x3C0..0x3DF inclusive.
- R4: Offsets 0x07, 0x08, 0x09 and 0x0A read 0x00. Offset 0x0B reads 0x03 and ignores writes.
- R5: Offsets 0x10, 0x11 and 0x12 read 0x08, 0x00 and 0x00. Offset 0x13 is read/write, resets to 0x00, and drives fb_base.
- R6: A read of offset 0x30 returns only bit 0 of the last written byte, and that bit drives rom_en. The bit resets to 0. Offset 0x31 reads 0x00.
- R7: Offsets 0x32 and 0x33 are read/write and reset to 0x0C and 0x00. rom_base[7:0] is offset 0x32 and rom_base[15:8] is offset 0x33. They hold their value when no write to them occurs.
- R8: Offset 0x3C is a read/write interrupt line that resets to 0x00 and drives irq_line. Offset 0x3D reads 0x01.
- R9: Every other offset (for example 0x05, 0x40, 0xFF) reads 0x00, and writes to it change no output.
- R10: The byte for a read request appears on cfg_rdata with cfg_rvalid high in the next cycle. cfg_rvalid is low after a write or an idle cycle, and cfg_rdata is then 0x00.
- R11: remap_pulse is high for one cycle, the cycle after a write to offset 0x04 or 0x13. Any other write leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read response strobe |
| io_port | input | 16 | I/O address to classify |
| vga_io_hit | output | 1 | I/O address is in the enabled VGA window |
| io_en | output | 1 | I/O space enable |
| mem_en | output | 1 | Memory space enable |
| fb_base | output | 8 | Frame-buffer base bits 31:24 |
| rom_en | output | 1 | Expansion ROM enable |
| rom_base | output | 16 | Expansion ROM base bits 31:16 |
| irq_line | output | 8 | Interrupt line value |
| remap_pulse | output | 1 | Aperture re-decode request |

## Verification
Two functions can act in the same cycle. A command write that flips the I/O enable can coincide with a port lookup, and the same write raises the remap pulse. The bench holds an in-window port on io_port while it writes the command byte. It then checks that vga_io_hit follows only after the write edge, in the same cycle that remap_pulse is high. A read that directly follows a write to the same offset must return the new, masked value, and this is judged against bench-computed values.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
    localparam int CFG_W = 8;

    localparam logic [7:0] OFS_CMD    = 8'h04;
    localparam logic [7:0] OFS_FB     = 8'h13;
    localparam logic [7:0] OFS_ROMCTL = 8'h30;
    localparam logic [7:0] OFS_ROMLO  = 8'h32;
    localparam logic [7:0] OFS_ROMHI  = 8'h33;
    localparam logic [7:0] OFS_IRQ    = 8'h3C;

    localparam logic [7:0] CMD_WMASK   = 8'h23;
    localparam logic [7:0] CMD_RESET   = 8'h07;
    localparam logic [7:0] ROMLO_RESET = 8'h0C;

    typedef struct packed {
        logic [CFG_W-1:0] cmd;
        logic [CFG_W-1:0] fb_hi;
        logic             rom_on;
        logic [CFG_W-1:0] rom_lo;
        logic [CFG_W-1:0] rom_hi;
        logic [CFG_W-1:0] irq;
    } cfg_state_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_t;
endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs
    import pcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] addr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_state_t       st,
    output logic             remap
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.cmd    <= CMD_RESET;
            st.fb_hi  <= '0;
            st.rom_on <= 1'b0;
            st.rom_lo <= ROMLO_RESET;
            st.rom_hi <= '0;
            st.irq    <= '0;
            remap     <= 1'b0;
        end else begin
            remap <= 1'b0;
            if (wr_en) begin
                unique case (addr)
                    OFS_CMD: begin
                        st.cmd <= wdata & CMD_WMASK;
                        remap  <= 1'b1;
                    end
                    OFS_FB: begin
                        st.fb_hi <= wdata;
                        remap    <= 1'b1;
                    end
                    OFS_ROMCTL: st.rom_on <= wdata[0];
                    OFS_ROMLO:  st.rom_lo <= wdata;
                    OFS_ROMHI:  st.rom_hi <= wdata;
                    OFS_IRQ:    st.irq    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // R2
    cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CMD) |=> (st.cmd == ($past(wdata) & CMD_WMASK)));

    // R7
    rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(st.rom_lo) && $stable(st.rom_hi)));
endmodule

// File: rtl/pcfg_rdmux.sv
module pcfg_rdmux
    import pcfg_pkg::*;
#(
    parameter bit DEV_SUPPORTED = 1'b1
) (
    input  logic [CFG_W-1:0] addr,
    input  cfg_state_t       st,
    output logic [CFG_W-1:0] rd
);
    localparam logic [7:0] DEVID_LO = DEV_SUPPORTED ? 8'hA0 : 8'hFF;

    always_comb begin
        unique case (addr)
            8'h00:      rd = 8'h13;
            8'h01:      rd = 8'h10;
            8'h02:      rd = DEVID_LO;
            OFS_CMD:    rd = st.cmd;
            8'h0B:      rd = 8'h03;
            8'h10:      rd = 8'h08;
            OFS_FB:     rd = st.fb_hi;
            OFS_ROMCTL: rd = {7'd0, st.rom_on};
            OFS_ROMLO:  rd = st.rom_lo;
            OFS_ROMHI:  rd = st.rom_hi;
            OFS_IRQ:    rd = st.irq;
            8'h3D:      rd = 8'h01;
            default:    rd = '0;
        endcase
    end
endmodule

// File: rtl/pcfg_iodec.sv
module pcfg_iodec #(
    parameter int          PORT_W  = 16,
    parameter logic [15:0] WIN_LO  = 16'h03C0,
    parameter int          WIN_CNT = 32
) (
    input  logic              io_en,
    input  logic [PORT_W-1:0] port,
    output logic              hit
);
    localparam logic [PORT_W-1:0] LO = PORT_W'(WIN_LO);
    localparam logic [PORT_W-1:0] HI = PORT_W'(WIN_LO + WIN_CNT - 1);

    always_comb hit = io_en && (port >= LO) && (port <= HI);
endmodule

// File: rtl/pcfg_responder.sv
module pcfg_responder
    import pcfg_pkg::*;
#(
    parameter bit DEV_SUPPORTED = 1'b1,
    parameter int PORT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              cfg_rvalid,
    input  logic [PORT_W-1:0] io_port,
    output logic              vga_io_hit,
    output logic              io_en,
    output logic              mem_en,
    output logic [CFG_W-1:0]  fb_base,
    output logic              rom_en,
    output logic [2*CFG_W-1:0] rom_base,
    output logic [CFG_W-1:0]  irq_line,
    output logic              remap_pulse
);
    cfg_state_t       st;
    logic [CFG_W-1:0] rd_byte;
    logic [CFG_W-1:0] rd_q;
    acc_state_t       state_q, state_d;
    logic             rd_req;

    assign rd_req = cfg_req && !cfg_we;

    pcfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_req && cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .st    (st),
        .remap (remap_pulse)
    );

    pcfg_rdmux #(.DEV_SUPPORTED(DEV_SUPPORTED)) u_rdmux (
        .addr (cfg_addr),
        .st   (st),
        .rd   (rd_byte)
    );

    pcfg_iodec #(.PORT_W(PORT_W)) u_iodec (
        .io_en (io_en),
        .port  (io_port),
        .hit   (vga_io_hit)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rd_q <= rd_byte;
        end
    end

    always_comb begin
        cfg_rvalid = (state_q == ST_RESP);
        cfg_rdata  = cfg_rvalid ? rd_q : '0;
        io_en      = st.cmd[0];
        mem_en     = st.cmd[1];
        fb_base    = st.fb_hi;
        rom_en     = st.rom_on;
        rom_base   = {st.rom_hi, st.rom_lo};
        irq_line   = st.irq;
    end

    // R10
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> $past(cfg_req && !cfg_we));

    // R11
    remap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> $past(cfg_req && cfg_we &&
                              (cfg_addr == OFS_CMD || cfg_addr == OFS_FB)));

    // R5
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && cfg_we && cfg_addr == OFS_FB) |=> $stable(fb_base));
endmodule

// File: tb/tb_pcfg_responder.sv
module tb_pcfg_responder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 43;

    // {we, addr, wdata, expected read}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0,8'h00,8'h00,8'h13}, {1'b0,8'h01,8'h00,8'h10},
        {1'b0,8'h02,8'h00,8'hA0}, {1'b0,8'h03,8'h00,8'h00},
        {1'b0,8'h04,8'h00,8'h07}, {1'b0,8'h05,8'h00,8'h00},
        {1'b0,8'h07,8'h00,8'h00}, {1'b0,8'h08,8'h00,8'h00},
        {1'b0,8'h09,8'h00,8'h00}, {1'b0,8'h0A,8'h00,8'h00},
        {1'b0,8'h0B,8'h00,8'h03}, {1'b0,8'h10,8'h00,8'h08},
        {1'b0,8'h11,8'h00,8'h00}, {1'b0,8'h12,8'h00,8'h00},
        {1'b0,8'h13,8'h00,8'h00}, {1'b0,8'h30,8'h00,8'h00},
        {1'b0,8'h31,8'h00,8'h00}, {1'b0,8'h32,8'h00,8'h0C},
        {1'b0,8'h33,8'h00,8'h00}, {1'b0,8'h3C,8'h00,8'h00},
        {1'b0,8'h3D,8'h00,8'h01}, {1'b0,8'h40,8'h00,8'h00},
        {1'b0,8'hFF,8'h00,8'h00},
        {1'b1,8'h04,8'hFF,8'h00}, {1'b0,8'h04,8'h00,8'h23},
        {1'b1,8'h13,8'hAB,8'h00}, {1'b0,8'h13,8'h00,8'hAB},
        {1'b1,8'h30,8'hFF,8'h00}, {1'b0,8'h30,8'h00,8'h01},
        {1'b1,8'h32,8'h55,8'h00}, {1'b1,8'h33,8'hE0,8'h00},
        {1'b0,8'h32,8'h00,8'h55}, {1'b0,8'h33,8'h00,8'hE0},
        {1'b1,8'h3C,8'h0E,8'h00}, {1'b0,8'h3C,8'h00,8'h0E},
        {1'b1,8'h00,8'h55,8'h00}, {1'b0,8'h00,8'h00,8'h13},
        {1'b1,8'h40,8'h77,8'h00}, {1'b0,8'h40,8'h00,8'h00},
        {1'b1,8'h0B,8'h11,8'h00}, {1'b0,8'h0B,8'h00,8'h03},
        {1'b1,8'h04,8'h00,8'h00}, {1'b0,8'h04,8'h00,8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] io_port = '0;
    logic [7:0]  cfg_rdata, alt_rdata;
    logic        cfg_rvalid, alt_rvalid;
    logic        vga_io_hit, io_en, mem_en, rom_en, remap_pulse;
    logic [7:0]  fb_base, irq_line;
    logic [15:0] rom_base;
    logic        alt_hit, alt_io, alt_mem, alt_rom, alt_remap;
    logic [7:0]  alt_fb, alt_irq;
    logic [15:0] alt_rombase;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_responder dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .io_port(io_port), .vga_io_hit(vga_io_hit),
        .io_en(io_en), .mem_en(mem_en), .fb_base(fb_base), .rom_en(rom_en),
        .rom_base(rom_base), .irq_line(irq_line), .remap_pulse(remap_pulse)
    );

    pcfg_responder #(.DEV_SUPPORTED(1'b0)) dut_alt (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(alt_rdata),
        .cfg_rvalid(alt_rvalid), .io_port(io_port), .vga_io_hit(alt_hit),
        .io_en(alt_io), .mem_en(alt_mem), .fb_base(alt_fb), .rom_en(alt_rom),
        .rom_base(alt_rombase), .irq_line(alt_irq), .remap_pulse(alt_remap)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h01, 8'h02, 8'h03: return "R1";
            8'h04:                      return "R2";
            8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B: return "R4";
            8'h10, 8'h11, 8'h12, 8'h13: return "R5";
            8'h30, 8'h31:               return "R6";
            8'h32, 8'h33:               return "R7";
            8'h3C, 8'h3D:               return "R8";
            default:                    return "R9";
        endcase
    endfunction

    // Issue one access; returns at the negedge after the capturing edge.
    task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state of outputs: R2 R5 R6 R7 R8 R10 R11
        chk("R2 io_en reset", 16'(io_en), 16'h1);
        chk("R2 mem_en reset", 16'(mem_en), 16'h1);
        chk("R5 fb_base reset", 16'(fb_base), 16'h00);
        chk("R6 rom_en reset", 16'(rom_en), 16'h0);
        chk("R7 rom_base reset", rom_base, 16'h000C);
        chk("R8 irq_line reset", 16'(irq_line), 16'h00);
        chk("R10 rvalid reset", 16'(cfg_rvalid), 16'h0);
        chk("R11 remap reset", 16'(remap_pulse), 16'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            if (!VEC[i][24]) begin
                chk({tag_of(VEC[i][23:16]), " read"}, 16'(cfg_rdata), 16'(VEC[i][7:0]));
                chk("R10 rvalid after read", 16'(cfg_rvalid), 16'h1);
            end else begin
                chk("R10 no rvalid after write", 16'(cfg_rvalid), 16'h0);
                chk("R10 rdata zero after write", 16'(cfg_rdata), 16'h00);
            end
        end

        // Outputs after the table
        chk("R2 io_en cleared", 16'(io_en), 16'h0);
        chk("R2 mem_en cleared", 16'(mem_en), 16'h0);
        chk("R5 fb_base", 16'(fb_base), 16'h00AB);
        chk("R6 rom_en", 16'(rom_en), 16'h1);
        chk("R7 rom_base", rom_base, 16'hE055);
        chk("R8 irq_line", 16'(irq_line), 16'h0E);

        // R1 unsupported device ID variant
        access(1'b0, 8'h02, 8'h00);
        chk("R1 devid low unsupported", 16'(alt_rdata), 16'h00FF);

        // R3 / R11 coincidence: command write while an in-window port is held
        io_port = 16'h03C0;
        @(negedge clk);
        chk("R3 hit while disabled", 16'(vga_io_hit), 16'h0);
        access(1'b1, 8'h04, 8'h01);
        chk("R3 hit after enable", 16'(vga_io_hit), 16'h1);
        chk("R11 remap with enable", 16'(remap_pulse), 16'h1);
        @(negedge clk);
        chk("R11 remap one cycle", 16'(remap_pulse), 16'h0);
        io_port = 16'h03DF; #1;
        chk("R3 top of window", 16'(vga_io_hit), 16'h1);
        io_port = 16'h03BF; #1;
        chk("R3 below window", 16'(vga_io_hit), 16'h0);
        io_port = 16'h03E0; #1;
        chk("R3 above window", 16'(vga_io_hit), 16'h0);

        // R11 other writes give no pulse; fb write does
        access(1'b1, 8'h3C, 8'h05);
        chk("R11 no remap on irq write", 16'(remap_pulse), 16'h0);
        access(1'b1, 8'h13, 8'h40);
        chk("R11 remap on fb write", 16'(remap_pulse), 16'h1);
        chk("R5 fb_base updated", 16'(fb_base), 16'h0040);

        // R9 write to unimplemented offset leaves outputs alone
        access(1'b1, 8'h05, 8'hFF);
        chk("R9 no remap", 16'(remap_pulse), 16'h0);
        chk("R9 io_en kept", 16'(io_en), 16'h1);
        chk("R9 mem_en kept", 16'(mem_en), 16'h0);
        chk("R9 rom_base kept", rom_base, 16'hE055);

        // R10 back-to-back reads keep rvalid high
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = 8'h3D;
        @(negedge clk);
        chk("R10 first of pair", 16'(cfg_rdata), 16'h01);
        cfg_addr = 8'h0B;
        @(negedge clk);
        cfg_req = 1'b0;
        chk("R10 second of pair", 16'(cfg_rdata), 16'h03);
        chk("R10 rvalid held", 16'(cfg_rvalid), 16'h1);
        @(negedge clk);
        chk("R10 rvalid drops", 16'(cfg_rvalid), 16'h0);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end
endmodule